// File: doc/BRIEF.md
# External Bus Cycle Controller with Address Latch Strobe

This block is the bus master that a processor core uses to reach external memory and I/O devices over separate address and data buses. The core hands it one request at a time: an address, write data, a read/write flag and a memory/I/O flag. The controller then runs a fixed four-phase cycle (T1, T2, T3, T4) on the external pins. It drives the address, a chip select and an address latch strobe (ALE). It drives the read or write strobe together with a memory-request or I/O-request qualifier. It can also drive the write data bus.

Every phase lasts a programmable number of system clocks. The value is sampled when the request is accepted. A slow device pulls the ready input low before T3 to stretch the cycle by whole wait phases, each as long as a normal phase. Read data is captured when T4 begins. The core receives that data together with a one-clock completion pulse. The strobes are active low. ALE and the write-data enable are active high.

Top module: `xbc_bus_master`

## Requirements
- R1: After reset, bus_cs_n, bus_rd_n, bus_wr_n, bus_mreq_n and bus_iorq_n are high. bus_ale, bus_wdata_oe and done are low, req_ready is high and rd_data is zero.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both high. On that edge bus_cs_n goes low, bus_ale goes high and bus_addr takes req_addr. For a write, bus_wdata takes req_wdata and bus_wdata_oe goes high. While a cycle runs, req_ready is low and req_valid has no effect.
- R3: The phase length N is cfg_state_clks clamped to the range 2..15, so the values 0 and 1 give N=2. N is sampled at acceptance, and later changes to cfg_state_clks do not affect the running cycle. Without wait phases, bus_cs_n stays low for exactly 4N clocks.
- R4: bus_ale is high for the first floor(N/2) clocks of T1 and is low at all other times.
- R5: T2 begins N clocks after acceptance. At that point bus_rd_n (req_write=0) or bus_wr_n (req_write=1) goes low. At the same time, bus_mreq_n goes low when req_io=0, or bus_iorq_n goes low when req_io=1. The unused strobe and the unused qualifier stay high for the whole cycle.
- R6: The active read or write strobe returns high when T4 begins, at 3N+W·N clocks after acceptance, where W is the number of wait phases.
- R7: bus_rdy is sampled once on the clock edge one clock before T3 begins. A low level there inserts wait phases. A low level at any other time during T2 or T3 has no effect.
- R8: Each wait phase lasts N clocks. bus_rdy is sampled again on the last clock of each wait phase. The controller moves to T4 on the first such sample that is high.
- R9: For a read, rd_data takes bus_rdata on the edge where T4 begins. Later changes to bus_rdata are ignored, and rd_data keeps its value through following write cycles.
- R10: bus_addr, bus_wdata and bus_wdata_oe stay constant while bus_cs_n is low. bus_cs_n, bus_mreq_n, bus_iorq_n and bus_wdata_oe return to their idle levels on the last edge of T4.
- R11: done is high for exactly one clock, starting on the edge that ends T4. req_ready is high again in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request strobe |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| cfg_state_clks | input | CLK_W | Clocks per bus phase (clamped to 2..15) |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | External address bus |
| bus_wdata | output | DATA_W | External data bus, outgoing value |
| bus_wdata_oe | output | 1 | Data bus drive enable |
| bus_rdata | input | DATA_W | External data bus, incoming value |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_mreq_n | output | 1 | Memory qualifier, active low |
| bus_iorq_n | output | 1 | I/O qualifier, active low |
| bus_rdy | input | 1 | Ready; low requests wait phases |

## Verification
A phase counter that is off by one shows up within the first phase. ALE falls a clock early or late, or the strobe appears at a clock other than N. A wrong wait decision stretches or shortens the strobe and chip select by a whole N clocks, and that shows on the pins no later than T4. Reading bus_rdy at the wrong point inside T2 or T3 separates the "late low ready" case from the real wait case. If the data capture register is loaded on the wrong edge, rd_data takes the value that follows the capture edge. A phase sequence stuck outside idle shows at once as req_ready staying low and done never arriving.

// File: rtl/xbc_pkg.sv
package xbc_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_TW   = 3'd4,
      PH_T4   = 3'd5
   } phase_e;

   localparam int unsigned XBC_MIN_PHASE_CLKS = 2;
   localparam int unsigned XBC_MAX_PHASE_CLKS = 15;

endpackage

// File: rtl/xbc_state_timer.sv
module xbc_state_timer #(
   parameter int unsigned CLK_W    = 4,
   parameter int unsigned MIN_CLKS = 2,
   parameter int unsigned MAX_CLKS = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   input  logic [CLK_W-1:0] cfg_clks,
   output logic             last,
   output logic             pre_last,
   output logic             half_hit
);

   localparam logic [CLK_W-1:0] MIN_V = CLK_W'(MIN_CLKS);
   localparam logic [CLK_W-1:0] MAX_V = CLK_W'(MAX_CLKS);
   localparam logic [CLK_W-1:0] ONE   = CLK_W'(1);
   localparam logic [CLK_W-1:0] TWO   = CLK_W'(2);

   logic [CLK_W-1:0] n_eff;
   logic [CLK_W-1:0] n_q;
   logic [CLK_W-1:0] cnt_q;
   logic [CLK_W-1:0] half_v;

   // clamp the programmed length into the legal window
   always_comb begin
      if (cfg_clks < MIN_V)
         n_eff = MIN_V;
      else if (cfg_clks > MAX_V)
         n_eff = MAX_V;
      else
         n_eff = cfg_clks;
   end

   assign half_v   = n_q >> 1;
   assign last     = active && (cnt_q == (n_q - ONE));
   assign pre_last = active && (cnt_q == (n_q - TWO));
   assign half_hit = active && (cnt_q == (half_v - ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q   <= MIN_V;
         cnt_q <= '0;
      end else if (start) begin
         n_q   <= n_eff;
         cnt_q <= '0;
      end else if (active) begin
         cnt_q <= last ? '0 : cnt_q + ONE;
      end
   end

endmodule

// File: rtl/xbc_phase_seq.sv
module xbc_phase_seq
   import xbc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   last,
   input  logic   pre_last,
   input  logic   half_hit,
   input  logic   rdy,
   output logic   idle,
   output logic   active,
   output logic   ev_ale_fall,
   output logic   ev_t2,
   output logic   ev_t4,
   output logic   ev_end
);

   phase_e phase_q;
   logic   wait_q;

   assign idle        = (phase_q == PH_IDLE);
   assign active      = !idle;
   assign ev_ale_fall = (phase_q == PH_T1) && half_hit;
   assign ev_t2       = (phase_q == PH_T1) && last;
   assign ev_t4       = last && (((phase_q == PH_T3) && !wait_q) ||
                                 ((phase_q == PH_TW) && rdy));
   assign ev_end      = (phase_q == PH_T4) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         wait_q  <= 1'b0;
      end else begin
         if (start) begin
            phase_q <= PH_T1;
         end else if (last) begin
            unique case (phase_q)
               PH_T1:   phase_q <= PH_T2;
               PH_T2:   phase_q <= PH_T3;
               PH_T3:   phase_q <= wait_q ? PH_TW : PH_T4;
               PH_TW:   phase_q <= rdy ? PH_T4 : PH_TW;
               PH_T4:   phase_q <= PH_IDLE;
               default: phase_q <= PH_IDLE;
            endcase
         end
         // single look at ready, one clock before T3 opens
         if ((phase_q == PH_T2) && pre_last)
            wait_q <= !rdy;
         else if (start)
            wait_q <= 1'b0;
      end
   end

endmodule

// File: rtl/xbc_pin_stage.sv
module xbc_pin_stage #(
   parameter int unsigned ADDR_W         = 24,
   parameter int unsigned DATA_W         = 8,
   parameter bit          IDLE_DATA_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              req_write,
   input  logic              req_io,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              ev_ale_fall,
   input  logic              ev_t2,
   input  logic              ev_t4,
   input  logic              ev_end,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_wdata_oe,
   output logic              bus_cs_n,
   output logic              bus_ale,
   output logic              bus_rd_n,
   output logic              bus_wr_n,
   output logic              bus_mreq_n,
   output logic              bus_iorq_n
);

   logic wr_q;
   logic io_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q         <= 1'b0;
         io_q         <= 1'b0;
         bus_addr     <= '0;
         bus_wdata_oe <= 1'b0;
         bus_cs_n     <= 1'b1;
         bus_ale      <= 1'b0;
         bus_rd_n     <= 1'b1;
         bus_wr_n     <= 1'b1;
         bus_mreq_n   <= 1'b1;
         bus_iorq_n   <= 1'b1;
         rd_data      <= '0;
         done         <= 1'b0;
      end else begin
         done <= ev_end;
         if (start) begin
            wr_q         <= req_write;
            io_q         <= req_io;
            bus_addr     <= req_addr;
            bus_wdata_oe <= req_write;
            bus_cs_n     <= 1'b0;
            bus_ale      <= 1'b1;
         end
         if (ev_ale_fall)
            bus_ale <= 1'b0;
         if (ev_t2) begin
            bus_rd_n   <= wr_q;
            bus_wr_n   <= !wr_q;
            bus_mreq_n <= io_q;
            bus_iorq_n <= !io_q;
         end
         if (ev_t4) begin
            bus_rd_n <= 1'b1;
            bus_wr_n <= 1'b1;
            if (!wr_q)
               rd_data <= bus_rdata;
         end
         if (ev_end) begin
            bus_cs_n     <= 1'b1;
            bus_mreq_n   <= 1'b1;
            bus_iorq_n   <= 1'b1;
            bus_wdata_oe <= 1'b0;
         end
      end
   end

   // outgoing data register: either parked at zero between cycles or left holding
   generate
      if (IDLE_DATA_ZERO) begin : g_wd_park
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bus_wdata <= '0;
            else if (start)
               bus_wdata <= req_write ? req_wdata : '0;
            else if (ev_end)
               bus_wdata <= '0;
         end
      end else begin : g_wd_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bus_wdata <= '0;
            else if (start && req_write)
               bus_wdata <= req_wdata;
         end
      end
   endgenerate

endmodule

// File: rtl/xbc_bus_master.sv
module xbc_bus_master
   import xbc_pkg::*;
#(
   parameter int unsigned ADDR_W         = 24,
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned CLK_W          = 4,
   parameter int unsigned MIN_CLKS       = XBC_MIN_PHASE_CLKS,
   parameter int unsigned MAX_CLKS       = XBC_MAX_PHASE_CLKS,
   parameter bit          IDLE_DATA_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_io,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [CLK_W-1:0]  cfg_state_clks,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_wdata_oe,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              bus_cs_n,
   output logic              bus_ale,
   output logic              bus_rd_n,
   output logic              bus_wr_n,
   output logic              bus_mreq_n,
   output logic              bus_iorq_n,
   input  logic              bus_rdy
);

   localparam int unsigned CNT_SPAN = (1 << CLK_W) - 1;

   generate
      if (MIN_CLKS < 2) begin : g_bad_min
         $error("xbc_bus_master: MIN_CLKS must be at least 2");
      end
      if (MAX_CLKS < MIN_CLKS || MAX_CLKS > CNT_SPAN) begin : g_bad_max
         $error("xbc_bus_master: MAX_CLKS out of range for CLK_W");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("xbc_bus_master: bus widths must be positive");
      end
   endgenerate

   logic idle;
   logic active;
   logic start;
   logic last;
   logic pre_last;
   logic half_hit;
   logic ev_ale_fall;
   logic ev_t2;
   logic ev_t4;
   logic ev_end;

   assign req_ready = idle;
   assign start     = req_valid && idle;

   xbc_state_timer #(
      .CLK_W    (CLK_W),
      .MIN_CLKS (MIN_CLKS),
      .MAX_CLKS (MAX_CLKS)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .active   (active),
      .cfg_clks (cfg_state_clks),
      .last     (last),
      .pre_last (pre_last),
      .half_hit (half_hit)
   );

   xbc_phase_seq i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .last        (last),
      .pre_last    (pre_last),
      .half_hit    (half_hit),
      .rdy         (bus_rdy),
      .idle        (idle),
      .active      (active),
      .ev_ale_fall (ev_ale_fall),
      .ev_t2       (ev_t2),
      .ev_t4       (ev_t4),
      .ev_end      (ev_end)
   );

   xbc_pin_stage #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .IDLE_DATA_ZERO (IDLE_DATA_ZERO)
   ) i_pins (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .req_write    (req_write),
      .req_io       (req_io),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .ev_ale_fall  (ev_ale_fall),
      .ev_t2        (ev_t2),
      .ev_t4        (ev_t4),
      .ev_end       (ev_end),
      .bus_rdata    (bus_rdata),
      .done         (done),
      .rd_data      (rd_data),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_wdata_oe (bus_wdata_oe),
      .bus_cs_n     (bus_cs_n),
      .bus_ale      (bus_ale),
      .bus_rd_n     (bus_rd_n),
      .bus_wr_n     (bus_wr_n),
      .bus_mreq_n   (bus_mreq_n),
      .bus_iorq_n   (bus_iorq_n)
   );

endmodule

// File: rtl/xbc_bus_master_chk.sv
module xbc_bus_master_chk #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_wdata_oe,
   input logic              bus_cs_n,
   input logic              bus_ale,
   input logic              bus_rd_n,
   input logic              bus_wr_n,
   input logic              bus_mreq_n,
   input logic              bus_iorq_n
);

   assert_ale_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |-> !bus_cs_n);

   assert_ale_opens_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ale) |-> $fell(bus_cs_n));

   assert_busy_blocks_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cs_n |-> !req_ready);

   assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n && !bus_wr_n));

   assert_single_space_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_mreq_n && !bus_iorq_n));

   assert_strobe_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n || !bus_wr_n) |-> ((!bus_mreq_n || !bus_iorq_n) && !bus_cs_n));

   assert_strobe_off_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bus_rd_n && bus_wr_n));

   assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

   assert_wdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wdata_oe && $past(bus_wdata_oe)) |-> $stable(bus_wdata));

   assert_done_one_clk_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_with_cs_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($rose(bus_cs_n) && req_ready));

endmodule

bind xbc_bus_master xbc_bus_master_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) i_xbc_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready    (req_ready),
   .done         (done),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_wdata_oe (bus_wdata_oe),
   .bus_cs_n     (bus_cs_n),
   .bus_ale      (bus_ale),
   .bus_rd_n     (bus_rd_n),
   .bus_wr_n     (bus_wr_n),
   .bus_mreq_n   (bus_mreq_n),
   .bus_iorq_n   (bus_iorq_n)
);

// File: tb/test_xbc_bus_master.sv
module test_xbc_bus_master;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 24;
   localparam int DW = 8;

   typedef struct packed {
      logic          wr;
      logic          io;
      logic [3:0]    cfg;
      logic [2:0]    waits;
      logic [AW-1:0] addr;
      logic [DW-1:0] wdata;
      logic [DW-1:0] rdata;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 1'b0, 4'd2,  3'd0, 24'h001234, 8'h00, 8'hA5},
      '{1'b1, 1'b0, 4'd2,  3'd0, 24'h00ABCD, 8'h3C, 8'h00},
      '{1'b0, 1'b1, 4'd3,  3'd0, 24'h000080, 8'h00, 8'h5A},
      '{1'b1, 1'b1, 4'd4,  3'd1, 24'h0000FF, 8'hC3, 8'h00},
      '{1'b0, 1'b0, 4'd5,  3'd2, 24'h7F0001, 8'h00, 8'h81},
      '{1'b1, 1'b0, 4'd15, 3'd0, 24'hFFFFFE, 8'hE7, 8'h00},
      '{1'b0, 1'b0, 4'd0,  3'd1, 24'h400000, 8'h00, 8'h1F},
      '{1'b1, 1'b1, 4'd1,  3'd3, 24'h000010, 8'h96, 8'h00}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic          req_io = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [3:0]    cfg_state_clks = 4'd2;
   logic          done;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          bus_wdata_oe;
   logic [DW-1:0] bus_rdata = '0;
   logic          bus_cs_n;
   logic          bus_ale;
   logic          bus_rd_n;
   logic          bus_wr_n;
   logic          bus_mreq_n;
   logic          bus_iorq_n;
   logic          bus_rdy = 1'b1;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;
   logic [DW-1:0] last_rd = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xbc_bus_master i_xbc_bus_master (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_write      (req_write),
      .req_io         (req_io),
      .req_addr       (req_addr),
      .req_wdata      (req_wdata),
      .cfg_state_clks (cfg_state_clks),
      .done           (done),
      .rd_data        (rd_data),
      .bus_addr       (bus_addr),
      .bus_wdata      (bus_wdata),
      .bus_wdata_oe   (bus_wdata_oe),
      .bus_rdata      (bus_rdata),
      .bus_cs_n       (bus_cs_n),
      .bus_ale        (bus_ale),
      .bus_rd_n       (bus_rd_n),
      .bus_wr_n       (bus_wr_n),
      .bus_mreq_n     (bus_mreq_n),
      .bus_iorq_n     (bus_iorq_n),
      .bus_rdy        (bus_rdy)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // one full bus cycle, checked clock by clock against the requirement timing
   task automatic run_cycle(input vec_t v, input bit late, input bit poke,
                            input logic [3:0] cfg_mid);
      int n;
      int w;
      int len;
      int half;
      int t4;
      string tcs;
      n    = (v.cfg < 4'd2) ? 2 : int'(v.cfg);
      w    = late ? 0 : int'(v.waits);
      len  = 4*n + w*n;
      half = n/2;
      t4   = 3*n + w*n;
      tcs  = late ? "R7" : ((w > 0) ? "R8" : "R3");
      @(negedge clk);
      req_valid      = 1'b1;
      req_write      = v.wr;
      req_io         = v.io;
      req_addr       = v.addr;
      req_wdata      = v.wdata;
      cfg_state_clks = v.cfg;
      bus_rdy        = (w > 0) ? 1'b0 : 1'b1;
      bus_rdata      = v.rdata;
      for (int c = 0; c <= len; c++) begin
         bit in_cyc;
         bit str_lo;
         bit spc_lo;
         @(negedge clk);
         if (c == 0) req_valid = 1'b0;
         if (c == 1) cfg_state_clks = cfg_mid;
         if (poke && c == 2) begin
            req_valid = 1'b1;
            req_addr  = ~v.addr;
            req_wdata = ~v.wdata;
         end
         if (poke && c == 3) req_valid = 1'b0;
         in_cyc = (c < len);
         str_lo = (c >= n) && (c < t4);
         spc_lo = (c >= n) && in_cyc;
         chk(bus_cs_n == !in_cyc, tcs, "cs_n", 32'(bus_cs_n), 32'(!in_cyc));
         chk(bus_ale == (c < half), "R4", "ale", 32'(bus_ale), 32'(c < half));
         chk(bus_rd_n == !(str_lo && !v.wr), "R6", "rd_n", 32'(bus_rd_n), 32'(!(str_lo && !v.wr)));
         chk(bus_wr_n == !(str_lo && v.wr), "R6", "wr_n", 32'(bus_wr_n), 32'(!(str_lo && v.wr)));
         chk(bus_mreq_n == !(spc_lo && !v.io), "R5", "mreq_n", 32'(bus_mreq_n), 32'(!(spc_lo && !v.io)));
         chk(bus_iorq_n == !(spc_lo && v.io), "R5", "iorq_n", 32'(bus_iorq_n), 32'(!(spc_lo && v.io)));
         chk(bus_wdata_oe == (v.wr && in_cyc), "R10", "wdata_oe", 32'(bus_wdata_oe), 32'(v.wr && in_cyc));
         if (in_cyc) begin
            chk(bus_addr == v.addr, poke ? "R2" : "R10", "addr", 32'(bus_addr), 32'(v.addr));
            if (v.wr)
               chk(bus_wdata == v.wdata, poke ? "R2" : "R10", "wdata", 32'(bus_wdata), 32'(v.wdata));
         end
         chk(done == (c == len), "R11", "done", 32'(done), 32'(c == len));
         chk(req_ready == !in_cyc, "R11", "req_ready", 32'(req_ready), 32'(!in_cyc));
         if (c == len) begin
            if (!v.wr) last_rd = v.rdata;
            chk(rd_data == last_rd, "R9", "rd_data", 32'(rd_data), 32'(last_rd));
         end
         // drive inputs seen at edge c+1
         if (late)
            bus_rdy = !((c + 1 >= 2*n) && (c + 1 < 3*n));
         else
            bus_rdy = !((w > 0) && (c + 1 < t4));
         bus_rdata = (c + 1 <= t4) ? v.rdata : ~v.rdata;
      end
      bus_rdy = 1'b1;
      cfg_state_clks = v.cfg;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL R11 watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      vec_t lv;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset levels
      chk(bus_cs_n && bus_rd_n && bus_wr_n && bus_mreq_n && bus_iorq_n, "R1", "strobes",
          {27'd0, bus_cs_n, bus_rd_n, bus_wr_n, bus_mreq_n, bus_iorq_n}, 32'h1F);
      chk(!bus_ale && !bus_wdata_oe && !done, "R1", "ale/oe/done",
          {29'd0, bus_ale, bus_wdata_oe, done}, 32'h0);
      chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'h1);
      chk(rd_data == '0, "R1", "rd_data", 32'(rd_data), 32'h0);

      // table of vectors walked by one loop
      for (int i = 0; i < NVEC; i++)
         run_cycle(VECS[i], 1'b0, 1'b0, VECS[i].cfg);

      // R7: ready low only during T3 must not add waits
      lv = '{1'b0, 1'b1, 4'd3, 3'd0, 24'h0A0A0A, 8'h00, 8'h6E};
      run_cycle(lv, 1'b1, 1'b0, lv.cfg);

      // R2 and R3: request while busy and length change mid-cycle are ignored
      lv = '{1'b1, 1'b0, 4'd2, 3'd0, 24'h135790, 8'h47, 8'h00};
      run_cycle(lv, 1'b0, 1'b1, 4'd9);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(bus_cs_n == 1'b1, "R2", "cs_n after ignored request", 32'(bus_cs_n), 32'h1);
      end

      // R9: rd_data still holds the last read after that write
      chk(rd_data == last_rd, "R9", "rd_data held", 32'(rd_data), 32'(last_rd));

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule